// File: doc/BRIEF.md
# Dual-Station Card Read Verifier

This block checks that a punched card was read correctly by comparing two independent sensings of the same card. A card transport carries each card past a first read station and, one card cycle later, past a second read station. The block writes the column images from the first station into one buffer and those from the second station into another. At each cycle boundary it moves the first-station image into a one-card hold stage, so that the card now under the second station can be compared with its own earlier sensing.

The comparison covers every hole of every column, bit by bit. The block reports how many columns differ and raises a reject flag when any column differs. It then picks an output stacker for the card. A good card goes to the stacker chosen by the program. A rejected card, or a card whose requested stacker does not exist, goes to a configurable error stacker. Running counts of verified and rejected cards are available on output ports.

The next card can enter the first station while the previous card is still at the second. Because of this, the block accepts writes from both stations during the same card cycle.

Top module: `card_read_verifier`

## Requirements
- R1: After reset, `cycle_done`, `result_valid`, `rej_flag`, `bad_cols`, `stacker_out`, `verified_cnt` and `rejected_cnt` are all zero.
- R2: A column write with `col_station`=0 fills the first-station buffer, and one with `col_station`=1 fills the second-station buffer. Suppose `cycle_start` is high at a clock edge. Then `cycle_done` is high for the following cycle only (assuming `cycle_start` drops), and the first-station image moves into the hold stage. The first `cycle_start` after reset has no held card: it gives `result_valid`=0, `rej_flag`=0, `bad_cols`=0, unchanged counters and an unchanged `stacker_out`.
- R3: When a held card exists, `bad_cols` equals the number of columns whose hold-stage pattern differs in any bit from the second-station pattern, and `rej_flag` is 1 exactly when `bad_cols` is non-zero.
- R4: A rejected card drives `stacker_out` to the `err_stacker` value sampled with `cycle_start`, whatever `stacker_sel` holds.
- R5: A matching card drives `stacker_out` to `stacker_sel` when that value is below NUM_STACKERS. A value of NUM_STACKERS or more selects `err_stacker` instead.
- R6: Each compared card increments `verified_cnt` (match) or `rejected_cnt` (mismatch) by one. Both counters saturate at 2^CNT_W-1, and neither changes at any other time.
- R7: A column write is ignored when `col_idx` is NUM_COLS or above, and when it arrives in the same cycle as `cycle_start`.
- R8: Buffers are not cleared between cycles. A column that is not rewritten keeps its last value. Result outputs hold their values until the next `cycle_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| col_valid | input | 1 | Column write strobe |
| col_station | input | 1 | 0 = first station, 1 = second station |
| col_idx | input | IDX_W | Column number |
| col_holes | input | COL_BITS | Hole pattern of the column |
| cycle_start | input | 1 | Closes the current card cycle and starts the comparison |
| stacker_sel | input | SEL_W | Stacker requested by the program for a good card |
| err_stacker | input | SEL_W | Stacker reserved for rejected cards |
| cycle_done | output | 1 | One-cycle pulse when results update |
| result_valid | output | 1 | A card was compared in the last cycle |
| rej_flag | output | 1 | The compared card mismatched |
| bad_cols | output | BAD_W | Number of mismatching columns |
| stacker_out | output | SEL_W | Stacker chosen for the compared card |
| verified_cnt | output | CNT_W | Cards that matched |
| rejected_cnt | output | CNT_W | Cards that mismatched |

## Verification
The bench builds the block with six columns of six bits, three stackers and three-bit counters. Six columns leave a three-bit index, so indices 6 and 7 can be driven to exercise ignored writes. Three-bit counters reach saturation at 7 within a short sequence of matching cards. Three stackers leave select value 3 as the invalid code that must fall back to the error stacker.

// File: rtl/card_read_verifier.sv
module card_read_verifier #(
  parameter int NUM_COLS     = 90,
  parameter int COL_BITS     = 6,
  parameter int NUM_STACKERS = 3,
  parameter int CNT_W        = 16,
  localparam int IDX_W = $clog2(NUM_COLS),
  localparam int SEL_W = $clog2(NUM_STACKERS),
  localparam int BAD_W = $clog2(NUM_COLS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                col_valid,
  input  logic                col_station,
  input  logic [IDX_W-1:0]    col_idx,
  input  logic [COL_BITS-1:0] col_holes,
  input  logic                cycle_start,
  input  logic [SEL_W-1:0]    stacker_sel,
  input  logic [SEL_W-1:0]    err_stacker,
  output logic                cycle_done,
  output logic                result_valid,
  output logic                rej_flag,
  output logic [BAD_W-1:0]    bad_cols,
  output logic [SEL_W-1:0]    stacker_out,
  output logic [CNT_W-1:0]    verified_cnt,
  output logic [CNT_W-1:0]    rejected_cnt
);

  localparam logic [IDX_W:0] COL_LIM = NUM_COLS[IDX_W:0];
  localparam logic [SEL_W:0] STK_LIM = NUM_STACKERS[SEL_W:0];
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [COL_BITS-1:0] s1_buf   [NUM_COLS];
  logic [COL_BITS-1:0] s2_buf   [NUM_COLS];
  logic [COL_BITS-1:0] hold_buf [NUM_COLS];
  logic                hold_valid;

  logic                wr_ok;
  logic [NUM_COLS-1:0] col_diff;
  logic [BAD_W-1:0]    diff_cnt;
  logic                mismatch;
  logic                sel_ok;
  logic [SEL_W-1:0]    pick;

  assign wr_ok    = col_valid && !cycle_start && ({1'b0, col_idx} < COL_LIM);
  assign mismatch = |col_diff;
  assign sel_ok   = {1'b0, stacker_sel} < STK_LIM;
  assign pick     = (mismatch || !sel_ok) ? err_stacker : stacker_sel;

  for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
    assign col_diff[c] = |(hold_buf[c] ^ s2_buf[c]);
  end

  always_comb begin
    diff_cnt = '0;
    for (int i = 0; i < NUM_COLS; i++) diff_cnt = diff_cnt + BAD_W'(col_diff[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_COLS; i++) begin
        s1_buf[i]   <= '0;
        s2_buf[i]   <= '0;
        hold_buf[i] <= '0;
      end
    end else begin
      if (wr_ok && !col_station) s1_buf[col_idx] <= col_holes;
      if (wr_ok &&  col_station) s2_buf[col_idx] <= col_holes;
      if (cycle_start) hold_buf <= s1_buf;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_valid   <= 1'b0;
      cycle_done   <= 1'b0;
      result_valid <= 1'b0;
      rej_flag     <= 1'b0;
      bad_cols     <= '0;
      stacker_out  <= '0;
      verified_cnt <= '0;
      rejected_cnt <= '0;
    end else begin
      cycle_done <= cycle_start;
      if (cycle_start) begin
        hold_valid   <= 1'b1;
        result_valid <= hold_valid;
        if (hold_valid) begin
          rej_flag    <= mismatch;
          bad_cols    <= diff_cnt;
          stacker_out <= pick;
          if (mismatch && rejected_cnt != CNT_MAX) rejected_cnt <= rejected_cnt + 1'b1;
          if (!mismatch && verified_cnt != CNT_MAX) verified_cnt <= verified_cnt + 1'b1;
        end else begin
          rej_flag <= 1'b0;
          bad_cols <= '0;
        end
      end
    end
  end

  p_no_cmp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_done && !result_valid) |-> (!rej_flag && bad_cols == '0));

  p_flag_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_done && result_valid) |-> (rej_flag == (bad_cols != '0)));

  p_err_route_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_done && rej_flag) |-> (stacker_out == $past(err_stacker)));

  p_good_route_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_done && result_valid && !rej_flag && ({1'b0, $past(stacker_sel)} < STK_LIM))
      |-> (stacker_out == $past(stacker_sel)));

  p_cnt_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cycle_start |=> ($stable(verified_cnt) && $stable(rejected_cnt)));

  p_cnt_no_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rejected_cnt == CNT_MAX) |=> (rejected_cnt == CNT_MAX));

endmodule

// File: tb/card_read_verifier_tb_top.sv
module card_read_verifier_tb_top;
  localparam int NC = 6, CB = 6, NS = 3, CW = 3;

  logic clk = 0, rst_n = 0;
  logic col_valid = 0, col_station = 0, cycle_start = 0;
  logic [2:0] col_idx = 0;
  logic [CB-1:0] col_holes = 0;
  logic [1:0] stacker_sel = 0, err_stacker = 0;
  logic cycle_done, result_valid, rej_flag;
  logic [2:0] bad_cols;
  logic [1:0] stacker_out;
  logic [CW-1:0] verified_cnt, rejected_cnt;

  int checks = 0, errors = 0;
  bit finished = 0;

  logic [CB-1:0] m_b1 [NC], m_b2 [NC], m_hold [NC];
  bit m_hv = 0;
  int m_ver = 0, m_rej = 0, m_stk = 0;

  always #5 clk = ~clk;

  card_read_verifier #(.NUM_COLS(NC), .COL_BITS(CB), .NUM_STACKERS(NS), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .col_valid(col_valid), .col_station(col_station),
    .col_idx(col_idx), .col_holes(col_holes), .cycle_start(cycle_start),
    .stacker_sel(stacker_sel), .err_stacker(err_stacker), .cycle_done(cycle_done),
    .result_valid(result_valid), .rej_flag(rej_flag), .bad_cols(bad_cols),
    .stacker_out(stacker_out), .verified_cnt(verified_cnt), .rejected_cnt(rejected_cnt));

  function automatic logic [CB-1:0] pat(int s, int c);
    return CB'((s * 11 + c * 5 + 3) & 63);
  endfunction

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic wr(bit st, int idx, logic [CB-1:0] v);
    @(negedge clk);
    col_valid = 1; col_station = st; col_idx = 3'(idx); col_holes = v;
    if (idx < NC) begin
      if (st) m_b2[idx] = v; else m_b1[idx] = v;
    end
    @(negedge clk);
    col_valid = 0;
  endtask

  task automatic do_cycle(int sel, int err, bit wr_during, string tag);
    int exp_bad = 0;
    bit exp_valid;
    exp_valid = m_hv;
    if (m_hv) begin
      for (int c = 0; c < NC; c++) if (m_hold[c] != m_b2[c]) exp_bad++;
      if (exp_bad != 0) begin
        m_stk = err;
        if (m_rej < 7) m_rej++;
      end else begin
        m_stk = (sel < NS) ? sel : err;
        if (m_ver < 7) m_ver++;
      end
    end
    @(negedge clk);
    cycle_start = 1; stacker_sel = 2'(sel); err_stacker = 2'(err);
    if (wr_during) begin
      col_valid = 1; col_station = 1; col_idx = 1; col_holes = pat(6, 1);
    end
    @(negedge clk);
    cycle_start = 0; col_valid = 0;
    chk({tag, " R2 done"}, cycle_done, 1);
    chk({tag, " R2 valid"}, result_valid, exp_valid);
    chk({tag, " R3 bad_cols"}, bad_cols, exp_bad);
    chk({tag, " R3 rej_flag"}, rej_flag, exp_bad != 0);
    chk({tag, " R4/R5 stacker"}, stacker_out, m_stk);
    chk({tag, " R6 verified"}, verified_cnt, m_ver);
    chk({tag, " R6 rejected"}, rejected_cnt, m_rej);
    for (int c = 0; c < NC; c++) m_hold[c] = m_b1[c];
    m_hv = 1;
    @(negedge clk);
    chk({tag, " R2 done pulse"}, cycle_done, 0);
    chk({tag, " R8 held"}, stacker_out, m_stk);
  endtask

  task automatic t_reset;
    chk("R1 done", cycle_done, 0);
    chk("R1 valid", result_valid, 0);
    chk("R1 rej", rej_flag, 0);
    chk("R1 bad", bad_cols, 0);
    chk("R1 stacker", stacker_out, 0);
    chk("R1 ver", verified_cnt, 0);
    chk("R1 rej cnt", rejected_cnt, 0);
  endtask

  task automatic t_first;
    for (int c = 0; c < NC; c++) wr(0, c, pat(1, c));
    do_cycle(1, 2, 0, "first");
  endtask

  task automatic t_match;
    for (int c = 0; c < NC; c++) begin wr(1, c, pat(1, c)); wr(0, c, pat(2, c)); end
    do_cycle(1, 2, 0, "match");
  endtask

  task automatic t_mismatch;
    for (int c = 0; c < NC; c++) begin
      logic [CB-1:0] v = pat(2, c);
      if (c == 2) v ^= 6'h01;
      if (c == 4) v ^= 6'h20;
      wr(1, c, v); wr(0, c, pat(3, c));
    end
    do_cycle(0, 2, 0, "mismatch");
  endtask

  task automatic t_err_cfg;
    for (int c = 0; c < NC; c++) begin
      wr(1, c, (c == 0) ? (pat(3, c) ^ 6'h08) : pat(3, c)); wr(0, c, pat(4, c));
    end
    do_cycle(1, 0, 0, "err_cfg R4");
  endtask

  task automatic t_invalid_sel;
    for (int c = 0; c < NC; c++) begin wr(1, c, pat(4, c)); wr(0, c, pat(5, c)); end
    do_cycle(3, 1, 0, "invalid_sel R5");
  endtask

  task automatic t_ignore;
    for (int c = 0; c < NC; c++) begin wr(1, c, pat(5, c)); wr(0, c, pat(6, c)); end
    wr(0, 6, 6'h3f);
    wr(1, 7, 6'h2a);
    do_cycle(2, 1, 1, "ignore R7");
    for (int c = 0; c < NC; c++) if (c != 1) wr(1, c, pat(6, c));
    for (int c = 0; c < NC; c++) wr(0, c, pat(7, c));
    do_cycle(2, 1, 0, "retain R7 R8");
  endtask

  task automatic t_saturate;
    for (int k = 0; k < 8; k++) begin
      for (int c = 0; c < NC; c++) begin wr(1, c, m_b1[c]); wr(0, c, pat(8 + k, c)); end
      do_cycle(k % 3, 2, 0, "saturate");
    end
    chk("R6 verified saturates", verified_cnt, 7);
  endtask

  initial begin
    for (int c = 0; c < NC; c++) begin m_b1[c] = 0; m_b2[c] = 0; m_hold[c] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_first();
    t_match();
    t_mismatch();
    t_err_cfg();
    t_invalid_sel();
    t_ignore();
    t_saturate();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule